// File: doc/BRIEF.md
# Two-Operand Address Generator

This block works out where the two operands of a two-operand instruction live. It takes the source and destination mode fields, the register numbers, the register values, the operand-size flag, and up to two extension words that follow the opcode. From these it produces the source and destination effective addresses, flags that mark an operand as a register, the number of extension words the instruction uses, the address of the next opcode, and a writeback request for a source register that auto-increments.

The source mode is a 2-bit code: 00 register, 01 indexed, 10 indirect, 11 indirect with post-increment. The destination mode is one bit: 0 register, 1 indexed. Register 0 is the program counter. Register 2 is the status register, and it reads as zero when it is used as an index base. Three more modes come from these rules. Symbolic mode is indexed mode on register 0. Absolute mode is indexed mode on register 2. Immediate mode is post-increment on register 0. `pc_val` is the address of the word that directly follows the opcode. The address of each extension word, and of each immediate operand, is taken from this value.

A request is accepted in the cycle where `in_valid` is high. The results are registered and appear one clock later with `out_valid`.

Top module: `operand_agu`

## Requirements
- R1: Source mode 00 sets `src_is_reg` and destination mode 0 sets `dst_is_reg`. Neither uses an extension word, and the matching effective address output reads 0.
- R2: Indexed mode on any register other than 0 or 2 gives an effective address of register value plus the operand's extension word.
- R3: Indexed mode on register 0 (symbolic) uses the address of that operand's own extension word as its base. For the source this is `pc_val`. For the destination it is `pc_val`+2 if the source consumed a word, and `pc_val` otherwise.
- R4: Indexed mode on register 2 (absolute) uses a base of zero, so the extension word is the address. The register value is ignored.
- R5: Source mode 10 gives the register value as the address. It uses no extension word and requests no writeback.
- R6: Source mode 11 on a register other than 0 gives the register value as the address. It requests a writeback to that register of the value plus 1 for a byte operand or plus 2 for a word operand. No other mode requests a writeback.
- R7: Source mode 11 on register 0 (immediate) gives `pc_val` as the source address, consumes one extension word and requests no register writeback.
- R8: `ext_count` is the number of extension words consumed, from 0 to 2. The source word comes first in `ext0`. The destination word is taken from `ext1` when the source used a word, and from `ext0` otherwise.
- R9: The source post-increment is finished before the destination address is formed. An indexed destination on the same register as an auto-incrementing source uses the incremented value, not `dst_reg_val`.
- R10: For word operands (`byte_op`=0), bit 0 of both effective addresses is forced to 0. Byte operands keep the full address.
- R11: `pc_next` equals `pc_val` + 2 × `ext_count`.
- R12: After reset every output is 0. Outputs load one clock after a cycle with `in_valid`=1, with `out_valid`=1. In a cycle without `in_valid`, `out_valid` falls to 0 and the address outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_mode | input | 2 | Source mode code |
| src_reg | input | 4 | Source register number |
| dst_mode | input | 1 | Destination mode code |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| src_reg_val | input | 16 | Value of the source register |
| dst_reg_val | input | 16 | Value of the destination register |
| pc_val | input | 16 | Address of the word after the opcode |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| out_valid | output | 1 | Results valid |
| ext_count | output | 2 | Extension words consumed |
| src_is_reg | output | 1 | Source is a register |
| dst_is_reg | output | 1 | Destination is a register |
| src_ea | output | 16 | Source effective address |
| dst_ea | output | 16 | Destination effective address |
| wb_en | output | 1 | Register writeback request |
| wb_reg | output | 4 | Writeback register number |
| wb_data | output | 16 | Writeback value |
| pc_next | output | 16 | Address of the next opcode |

## Verification
The bench targets a destination on the same register as an auto-incrementing source. A design that ignores the source step would use the stale `dst_reg_val` and land two bytes low (one byte for a byte operand). It also drives a symbolic destination behind an immediate source: if the base did not move past the consumed immediate word, the address would come out 2 too small, and swapping `ext0` and `ext1` would show up as a destination offset of 0x0040 where 0x0200 is expected. It checks that absolute mode ignores the register value, and that byte operands keep an odd address while word operands lose bit 0. It also checks that an idle cycle leaves the addresses held.

// File: rtl/operand_agu.sv
module operand_agu #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    src_mode,
  input  logic [RW-1:0] src_reg,
  input  logic          dst_mode,
  input  logic [RW-1:0] dst_reg,
  input  logic          byte_op,
  input  logic [AW-1:0] src_reg_val,
  input  logic [AW-1:0] dst_reg_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] ext0,
  input  logic [AW-1:0] ext1,
  output logic          out_valid,
  output logic [1:0]    ext_count,
  output logic          src_is_reg,
  output logic          dst_is_reg,
  output logic [AW-1:0] src_ea,
  output logic [AW-1:0] dst_ea,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_data,
  output logic [AW-1:0] pc_next
);
  localparam logic [RW-1:0] PC_IDX = RW'(0);
  localparam logic [RW-1:0] ZB_IDX = RW'(2);
  localparam logic [1:0] SM_REG = 2'b00, SM_IDX = 2'b01, SM_IND = 2'b10, SM_INC = 2'b11;

  logic          s_pc, s_ext, s_inc, d_pc;
  logic [AW-1:0] step, s_val, s_base, s_raw, s_post, d_val, d_base, d_word, d_raw, mask;
  logic [1:0]    cnt;

  assign step   = byte_op ? AW'(1) : AW'(2);
  assign mask   = byte_op ? '1 : ~AW'(1);

  assign s_pc   = (src_reg == PC_IDX);
  assign s_ext  = (src_mode == SM_IDX) || (src_mode == SM_INC && s_pc);
  assign s_inc  = (src_mode == SM_INC) && !s_pc;
  assign s_val  = s_pc ? pc_val : src_reg_val;
  assign s_base = (src_reg == ZB_IDX) ? '0 : s_val;
  assign s_post = src_reg_val + step;

  always_comb begin
    case (src_mode)
      SM_IDX:  s_raw = s_base + ext0;
      SM_IND:  s_raw = s_val;
      SM_INC:  s_raw = s_val;
      default: s_raw = '0;
    endcase
  end

  assign d_pc   = (dst_reg == PC_IDX);
  assign d_val  = d_pc ? (s_ext ? pc_val + AW'(2) : pc_val)
                       : ((s_inc && dst_reg == src_reg) ? s_post : dst_reg_val);
  assign d_base = (dst_reg == ZB_IDX) ? '0 : d_val;
  assign d_word = s_ext ? ext1 : ext0;
  assign d_raw  = dst_mode ? d_base + d_word : '0;
  assign cnt    = 2'(s_ext) + 2'(dst_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ext_count  <= '0;
      src_is_reg <= 1'b0;
      dst_is_reg <= 1'b0;
      src_ea     <= '0;
      dst_ea     <= '0;
      wb_en      <= 1'b0;
      wb_reg     <= '0;
      wb_data    <= '0;
      pc_next    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ext_count  <= cnt;
        src_is_reg <= (src_mode == SM_REG);
        dst_is_reg <= !dst_mode;
        src_ea     <= s_raw & mask;
        dst_ea     <= d_raw & mask;
        wb_en      <= s_inc;
        wb_reg     <= s_inc ? src_reg : '0;
        wb_data    <= s_inc ? s_post : '0;
        pc_next    <= pc_val + {{(AW-3){1'b0}}, cnt, 1'b0};
      end
    end
  end
endmodule

// File: rtl/operand_agu_chk.sv
module operand_agu_chk #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    src_mode,
  input logic [RW-1:0] src_reg,
  input logic          dst_mode,
  input logic          byte_op,
  input logic [AW-1:0] src_reg_val,
  input logic [AW-1:0] pc_val,
  input logic          out_valid,
  input logic [1:0]    ext_count,
  input logic          src_is_reg,
  input logic          dst_is_reg,
  input logic [AW-1:0] src_ea,
  input logic [AW-1:0] dst_ea,
  input logic          wb_en,
  input logic [AW-1:0] pc_next
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(src_ea) && $stable(dst_ea))); // R12
  AST_REG_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_mode == 2'b00 && !dst_mode) |=> (ext_count == 2'd0 && src_is_reg && dst_is_reg)); // R1
  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ext_count <= 2'd2)); // R8
  AST_WB_ONLY_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_mode != 2'b11) |=> !wb_en); // R6
  AST_INDIRECT_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_mode == 2'b10 && src_reg != '0 && byte_op) |=> (src_ea == $past(src_reg_val) && !wb_en)); // R5
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !byte_op) |=> (!src_ea[0] && !dst_ea[0])); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pc_next == $past(pc_val) + {{(AW-3){1'b0}}, ext_count, 1'b0})); // R11
endmodule

bind operand_agu operand_agu_chk #(.AW(AW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_mode(src_mode),
  .src_reg(src_reg), .dst_mode(dst_mode), .byte_op(byte_op),
  .src_reg_val(src_reg_val), .pc_val(pc_val), .out_valid(out_valid),
  .ext_count(ext_count), .src_is_reg(src_is_reg), .dst_is_reg(dst_is_reg),
  .src_ea(src_ea), .dst_ea(dst_ea), .wb_en(wb_en), .pc_next(pc_next)
);

// File: tb/operand_agu_tb_top.sv
`timescale 1ns/1ps
module operand_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  src_mode = '0;
  logic [3:0]  src_reg = '0;
  logic        dst_mode = 1'b0;
  logic [3:0]  dst_reg = '0;
  logic        byte_op = 1'b0;
  logic [15:0] src_reg_val = '0, dst_reg_val = '0, pc_val = '0, ext0 = '0, ext1 = '0;
  logic        out_valid, src_is_reg, dst_is_reg, wb_en;
  logic [1:0]  ext_count;
  logic [3:0]  wb_reg;
  logic [15:0] src_ea, dst_ea, wb_data, pc_next;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  operand_agu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_mode(src_mode),
    .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg), .byte_op(byte_op),
    .src_reg_val(src_reg_val), .dst_reg_val(dst_reg_val), .pc_val(pc_val),
    .ext0(ext0), .ext1(ext1), .out_valid(out_valid), .ext_count(ext_count),
    .src_is_reg(src_is_reg), .dst_is_reg(dst_is_reg), .src_ea(src_ea),
    .dst_ea(dst_ea), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .pc_next(pc_next)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  sm;
    logic [3:0]  sr;
    logic        dm;
    logic [3:0]  dr;
    logic        bo;
    logic [15:0] srv;
    logic [15:0] drv;
    logic [15:0] e0;
    logic [1:0]  cnt;
    logic        sreg;
    logic        dreg;
    logic [15:0] sea;
    logic [15:0] dea;
    logic        wb;
    logic [3:0]  wreg;
    logic [15:0] wdat;
    logic [15:0] pcn;
  } vec_t;

  localparam int NV = 16;
  localparam logic [15:0] PC0 = 16'h1000;
  localparam logic [15:0] E1  = 16'h0200;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  2'd0, 4'd5, 1'b0, 4'd6, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd0, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1000}, // R1
    '{4'd2,  2'd1, 4'd5, 1'b0, 4'd6, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd1, 1'b0, 1'b1, 16'h3040, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1002}, // R2
    '{4'd10, 2'd1, 4'd5, 1'b0, 4'd6, 1'b1, 16'h3001, 16'h4000, 16'h0040, 2'd1, 1'b0, 1'b1, 16'h3041, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1002}, // R10
    '{4'd3,  2'd1, 4'd0, 1'b1, 4'd6, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd2, 1'b0, 1'b0, 16'h1040, 16'h4200, 1'b0, 4'd0, 16'h0000, 16'h1004}, // R3
    '{4'd4,  2'd1, 4'd2, 1'b1, 4'd2, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd2, 1'b0, 1'b0, 16'h0040, 16'h0200, 1'b0, 4'd0, 16'h0000, 16'h1004}, // R4
    '{4'd5,  2'd2, 4'd5, 1'b0, 4'd6, 1'b1, 16'h3001, 16'h4000, 16'h0040, 2'd0, 1'b0, 1'b1, 16'h3001, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1000}, // R5
    '{4'd6,  2'd3, 4'd5, 1'b0, 4'd6, 1'b0, 16'h3000, 16'h4000, 16'h0040, 2'd0, 1'b0, 1'b1, 16'h3000, 16'h0000, 1'b1, 4'd5, 16'h3002, 16'h1000}, // R6 word
    '{4'd6,  2'd3, 4'd5, 1'b0, 4'd6, 1'b1, 16'h3000, 16'h4000, 16'h0040, 2'd0, 1'b0, 1'b1, 16'h3000, 16'h0000, 1'b1, 4'd5, 16'h3001, 16'h1000}, // R6 byte
    '{4'd7,  2'd3, 4'd0, 1'b1, 4'd6, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd2, 1'b0, 1'b0, 16'h1000, 16'h4200, 1'b0, 4'd0, 16'h0000, 16'h1004}, // R7
    '{4'd7,  2'd3, 4'd0, 1'b1, 4'd0, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd2, 1'b0, 1'b0, 16'h1000, 16'h1202, 1'b0, 4'd0, 16'h0000, 16'h1004}, // R7 + R3
    '{4'd3,  2'd0, 4'd5, 1'b1, 4'd0, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h1040, 1'b0, 4'd0, 16'h0000, 16'h1002}, // R3
    '{4'd8,  2'd0, 4'd5, 1'b1, 4'd6, 1'b0, 16'h3001, 16'h4000, 16'h0040, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h4040, 1'b0, 4'd0, 16'h0000, 16'h1002}, // R8
    '{4'd9,  2'd3, 4'd5, 1'b1, 4'd5, 1'b0, 16'h3000, 16'h4000, 16'h0040, 2'd1, 1'b0, 1'b0, 16'h3000, 16'h3042, 1'b1, 4'd5, 16'h3002, 16'h1002}, // R9 word
    '{4'd9,  2'd3, 4'd5, 1'b1, 4'd5, 1'b1, 16'h3000, 16'h4000, 16'h0040, 2'd1, 1'b0, 1'b0, 16'h3000, 16'h3041, 1'b1, 4'd5, 16'h3001, 16'h1002}, // R9 byte
    '{4'd10, 2'd0, 4'd5, 1'b1, 4'd6, 1'b0, 16'h3001, 16'h4001, 16'h0040, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h4040, 1'b0, 4'd0, 16'h0000, 16'h1002}, // R10 word
    '{4'd10, 2'd0, 4'd5, 1'b1, 4'd6, 1'b1, 16'h3001, 16'h4001, 16'h0040, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h4041, 1'b0, 4'd0, 16'h0000, 16'h1002}  // R10 byte
  };

  task automatic check(input string tag, input int idx, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s case %0d: actual=%h expected=%h", tag, idx, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src_mode = v.sm; src_reg = v.sr; dst_mode = v.dm; dst_reg = v.dr;
    byte_op = v.bo; src_reg_val = v.srv; dst_reg_val = v.drv;
    pc_val = PC0; ext0 = v.e0; ext1 = E1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset out_valid", 0, 16'(out_valid), 16'h0);
    check("R12 reset src_ea", 0, src_ea, 16'h0);
    check("R12 reset dst_ea", 0, dst_ea, 16'h0);
    check("R12 reset wb_en", 0, 16'(wb_en), 16'h0);
    check("R12 reset pc_next", 0, pc_next, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d", VECS[i].req);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      check("R12 out_valid", i, 16'(out_valid), 16'h1);
      check("R8 ext_count", i, 16'(ext_count), 16'(VECS[i].cnt));
      check({t, " src_is_reg"}, i, 16'(src_is_reg), 16'(VECS[i].sreg));
      check({t, " dst_is_reg"}, i, 16'(dst_is_reg), 16'(VECS[i].dreg));
      check({t, " src_ea"}, i, src_ea, VECS[i].sea);
      check({t, " dst_ea"}, i, dst_ea, VECS[i].dea);
      check({t, " wb_en"}, i, 16'(wb_en), 16'(VECS[i].wb));
      if (VECS[i].wb) begin
        check({t, " wb_reg"}, i, 16'(wb_reg), 16'(VECS[i].wreg));
        check({t, " wb_data"}, i, wb_data, VECS[i].wdat);
      end
      check("R11 pc_next", i, pc_next, VECS[i].pcn);
    end

    // R12 idle cycle: inputs change but outputs hold, out_valid drops
    in_valid = 1'b0;
    src_mode = 2'b01; src_reg = 4'd7; src_reg_val = 16'h7777; ext0 = 16'h0002;
    dst_mode = 1'b1; dst_reg = 4'd8; dst_reg_val = 16'h8888;
    @(negedge clk);
    check("R12 idle out_valid", 100, 16'(out_valid), 16'h0);
    check("R12 idle src_ea hold", 100, src_ea, 16'h0000);
    check("R12 idle dst_ea hold", 100, dst_ea, 16'h4041);

    // R4 absolute source ignores the register value entirely
    src_mode = 2'b01; src_reg = 4'd2; src_reg_val = 16'hFFFF; ext0 = 16'h0123;
    dst_mode = 1'b0; byte_op = 1'b1; pc_val = 16'h2000;
    in_valid = 1'b1;
    @(negedge clk);
    check("R4 absolute src_ea", 101, src_ea, 16'h0123);
    check("R11 absolute pc_next", 101, pc_next, 16'h2002);

    // R1 reg-to-reg after a memory operand clears the addresses
    src_mode = 2'b00; dst_mode = 1'b0;
    @(negedge clk);
    check("R1 src_ea zero", 102, src_ea, 16'h0000);
    check("R1 dst_ea zero", 102, dst_ea, 16'h0000);
    in_valid = 1'b0;

    // R12 synchronous reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 re-reset pc_next", 103, pc_next, 16'h0000);
    check("R12 re-reset out_valid", 103, 16'(out_valid), 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule